// File: doc/BRIEF.md
# Offload Command Sequencer

This block replays a stored list of bus commands to a downstream transfer engine, so that no processor is needed once the list is loaded. It holds two register-file memories, one for command words and one for outgoing payload words. Each memory is loaded through its own write port.

When a trigger arrives while the block is idle and offload operation is selected, the block runs one burst. It presents the programmed number of commands one after another on a valid/ready command channel. After each write command it offers that command's payload bytes on a valid/ready byte channel. When the last command of the burst completes, the block drops its busy flag and returns both its command pointer and its payload pointer to entry 0. The next trigger therefore replays the same list.

The bus transfer engine and the trigger source are outside the block.

Top module: `ofl_cmd_sequencer`

## Requirements
- R1: While reset is asserted and after its release, `busy`, `cmd_valid` and `sdo_valid` are low until a trigger is accepted.
- R2: A trigger sampled while idle, with `offload_en` = 1 and `burst_len` nonzero, raises `busy` and `cmd_valid` on the next cycle. The command presented then is exactly the stored 32-bit word at command entry 0.
- R3: Command entries 0 to `burst_len`-1 are presented in ascending order. Each entry is presented exactly once and is held stable until `cmd_ready` is seen.
- R4: Bit 0 of a command word is read-not-write (1 = read). Bits 19:8 of a command word hold a payload length N. After a write command is accepted, min(N,4) bytes of the current payload word are offered, byte 0 (bits 7:0) first and then upward. Each byte is held until `sdo_ready` is seen. No bytes are offered for a read command or when N = 0.
- R5: The payload pointer moves to the next payload word after every write command, whatever its length, including 0. A read command does not move it.
- R6: After `burst_len` commands have completed, `busy` falls. Both pointers return to entry 0, so the next burst starts again from command 0 and payload word 0.
- R7: A trigger that arrives while `busy` is high is ignored. It neither restarts the burst in progress nor starts a new burst afterwards, even when it coincides with the final handshake.
- R8: A trigger with `offload_en` = 0 is ignored, and `busy` stays low.
- R9: A trigger with `burst_len` = 0 issues no command, and `busy` stays low.
- R10: `cmd_valid` and `sdo_valid` are never high in the same cycle.
- R11: A write-enable pulse on either memory port stores the data at the given entry. A later burst uses the new content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| offload_en | input | 1 | 1 selects offload operation; 0 selects direct transfers, in which case triggers are ignored |
| burst_len | input | 4 | Number of commands executed per burst |
| trigger | input | 1 | Starts a burst when sampled high while idle |
| cmd_mem_we | input | 1 | Command memory write enable |
| cmd_mem_addr | input | 4 | Command memory entry |
| cmd_mem_wdata | input | 32 | Command word to store |
| pay_mem_we | input | 1 | Payload memory write enable |
| pay_mem_addr | input | 4 | Payload memory entry |
| pay_mem_wdata | input | 32 | Payload word to store, byte 0 in bits 7:0 |
| busy | output | 1 | High from the cycle after an accepted trigger until the burst completes |
| cmd_valid | output | 1 | A command word is presented |
| cmd_ready | input | 1 | The transfer engine accepts the command |
| cmd_word | output | 32 | Presented command word |
| sdo_valid | output | 1 | A payload byte is presented |
| sdo_ready | input | 1 | The transfer engine accepts the byte |
| sdo_byte | output | 8 | Presented payload byte |

## Verification
The most delicate coincidence is a trigger that lands in the same cycle as the handshake that completes the last command of a burst. At that moment the block is still busy, so the trigger must be dropped and no second burst may follow.

The bench provokes this by holding `trigger` high for the whole burst and releasing it only once `busy` is seen low. It then confirms three things: the collected command and byte streams match a single pass of the list, `busy` stays low afterwards, and a later burst still starts cleanly from entry 0. Stalling ready patterns shift where the final handshake falls, so the coincidence is met with both channels in different phases.

// File: rtl/ofl_pkg.sv
package ofl_pkg;
  localparam int CMD_RNW_BIT = 0;
  localparam int CMD_LEN_LSB = 8;
  localparam int CMD_LEN_W   = 12;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2
  } ofl_state_e;
endpackage

// File: rtl/ofl_regfile.sv
module ofl_regfile #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic ent_en;
    assign ent_en = we && (waddr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[i] <= '0;
      end else if (ent_en) begin
        mem_q[i] <= wdata;
      end
    end
  end

  assign rdata = mem_q[raddr];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem_q[$past(waddr)] == $past(wdata)); // R11
endmodule

// File: rtl/ofl_seq_ctrl.sv
module ofl_seq_ctrl
  import ofl_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int LEN_W  = 4,
  parameter int BLEN_W = 12,
  parameter int BYTES  = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int BW = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trigger,
  input  logic              offload_en,
  input  logic [LEN_W-1:0]  burst_len,
  input  logic              cmd_rnw,
  input  logic [BLEN_W-1:0] cmd_blen,
  input  logic              cmd_ready,
  input  logic              sdo_ready,
  output logic              busy,
  output logic              cmd_valid,
  output logic              sdo_valid,
  output logic [AW-1:0]     cmd_idx,
  output logic [AW-1:0]     pay_idx,
  output logic [BW-1:0]     byte_idx
);
  ofl_state_e    st_q, st_d;
  logic [AW-1:0] cmd_q, cmd_d;
  logic [AW-1:0] pay_q, pay_d;
  logic [BW-1:0] byte_q, byte_d;
  logic [BW-1:0] last_byte;
  logic          last_cmd;
  logic          advance;
  logic          start;

  // index of the final byte offered for the current command (clamped to one word)
  always_comb begin
    if (cmd_blen >= BLEN_W'(BYTES)) begin
      last_byte = BW'(BYTES - 1);
    end else begin
      last_byte = cmd_blen[BW-1:0] - BW'(1);
    end
  end

  assign last_cmd = ((LEN_W+1)'(cmd_q) + (LEN_W+1)'(1)) == {1'b0, burst_len};
  assign start    = trigger && offload_en && (burst_len != '0);

  always_comb begin
    st_d    = st_q;
    cmd_d   = cmd_q;
    pay_d   = pay_q;
    byte_d  = byte_q;
    advance = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) st_d = ST_CMD;
      end
      ST_CMD: begin
        if (cmd_ready) begin
          if (!cmd_rnw && (cmd_blen != '0)) begin
            st_d   = ST_DATA;
            byte_d = '0;
          end else begin
            advance = 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (sdo_ready) begin
          if (byte_q == last_byte) advance = 1'b1;
          else                     byte_d  = byte_q + BW'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (advance) begin
      if (!cmd_rnw) pay_d = pay_q + AW'(1);
      if (last_cmd) begin
        st_d  = ST_IDLE;
        cmd_d = '0;
        pay_d = '0;
      end else begin
        st_d  = ST_CMD;
        cmd_d = cmd_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cmd_q  <= '0;
      pay_q  <= '0;
      byte_q <= '0;
    end else begin
      st_q   <= st_d;
      cmd_q  <= cmd_d;
      pay_q  <= pay_d;
      byte_q <= byte_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign cmd_valid = (st_q == ST_CMD);
  assign sdo_valid = (st_q == ST_DATA);
  assign cmd_idx   = cmd_q;
  assign pay_idx   = pay_q;
  assign byte_idx  = byte_q;

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cmd_idx == '0 && pay_idx == '0); // R2
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_idx)); // R3
  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_valid && !sdo_ready |=> sdo_valid && $stable(byte_idx) && $stable(pay_idx)); // R4
  AST_SDO_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_valid |-> !cmd_rnw && cmd_blen != '0); // R4
  AST_READ_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_rnw |=> !busy || pay_idx == $past(pay_idx)); // R5
  AST_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cmd_idx == '0 && pay_idx == '0); // R6
  AST_NO_SPURIOUS_START: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !(trigger && offload_en) |=> !busy); // R8
endmodule

// File: rtl/ofl_cmd_sequencer.sv
module ofl_cmd_sequencer
  import ofl_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  parameter int LEN_W  = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int BYTES = WORD_W / 8,
  localparam int BW    = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              offload_en,
  input  logic [LEN_W-1:0]  burst_len,
  input  logic              trigger,
  input  logic              cmd_mem_we,
  input  logic [AW-1:0]     cmd_mem_addr,
  input  logic [WORD_W-1:0] cmd_mem_wdata,
  input  logic              pay_mem_we,
  input  logic [AW-1:0]     pay_mem_addr,
  input  logic [WORD_W-1:0] pay_mem_wdata,
  output logic              busy,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [WORD_W-1:0] cmd_word,
  output logic              sdo_valid,
  input  logic              sdo_ready,
  output logic [7:0]        sdo_byte
);
  logic              rst_meta_q, rst_sync_q;
  logic [AW-1:0]     cmd_idx, pay_idx;
  logic [BW-1:0]     byte_idx;
  logic [WORD_W-1:0] cmd_rdata, pay_rdata;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ofl_regfile #(.DEPTH(DEPTH), .WIDTH(WORD_W)) i_cmd_mem (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .we    (cmd_mem_we),
    .waddr (cmd_mem_addr),
    .wdata (cmd_mem_wdata),
    .raddr (cmd_idx),
    .rdata (cmd_rdata)
  );

  ofl_regfile #(.DEPTH(DEPTH), .WIDTH(WORD_W)) i_pay_mem (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .we    (pay_mem_we),
    .waddr (pay_mem_addr),
    .wdata (pay_mem_wdata),
    .raddr (pay_idx),
    .rdata (pay_rdata)
  );

  ofl_seq_ctrl #(
    .DEPTH  (DEPTH),
    .LEN_W  (LEN_W),
    .BLEN_W (CMD_LEN_W),
    .BYTES  (BYTES)
  ) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .trigger    (trigger),
    .offload_en (offload_en),
    .burst_len  (burst_len),
    .cmd_rnw    (cmd_rdata[CMD_RNW_BIT]),
    .cmd_blen   (cmd_rdata[CMD_LEN_LSB +: CMD_LEN_W]),
    .cmd_ready  (cmd_ready),
    .sdo_ready  (sdo_ready),
    .busy       (busy),
    .cmd_valid  (cmd_valid),
    .sdo_valid  (sdo_valid),
    .cmd_idx    (cmd_idx),
    .pay_idx    (pay_idx),
    .byte_idx   (byte_idx)
  );

  assign cmd_word = cmd_rdata;
  assign sdo_byte = pay_rdata[{byte_idx, 3'b000} +: 8];

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_sync_q)
    cmd_valid |=> !(cmd_valid && sdo_valid)); // R10
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !busy |-> !cmd_valid && !sdo_valid); // R1
endmodule

// File: tb/test_ofl_cmd_sequencer.sv
module test_ofl_cmd_sequencer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        offload_en, trigger;
  logic [3:0]  burst_len;
  logic        cmd_mem_we, pay_mem_we;
  logic [3:0]  cmd_mem_addr, pay_mem_addr;
  logic [31:0] cmd_mem_wdata, pay_mem_wdata;
  logic        busy, cmd_valid, cmd_ready, sdo_valid, sdo_ready;
  logic [31:0] cmd_word;
  logic [7:0]  sdo_byte;

  int total = 0;
  int bad   = 0;
  logic [31:0] tb_cmd [16];
  logic [31:0] tb_pay [16];
  logic [31:0] exp_cmd [64];
  logic [7:0]  exp_byte [256];
  logic [31:0] got_cmd [64];
  logic [7:0]  got_byte [256];
  int n_exp_cmd, n_exp_byte, n_got_cmd, n_got_byte, both_hi;

  always #(CLK_PERIOD/2) clk = ~clk;

  ofl_cmd_sequencer i_ofl_cmd_sequencer (
    .clk(clk), .rst_n(rst_n), .offload_en(offload_en), .burst_len(burst_len),
    .trigger(trigger), .cmd_mem_we(cmd_mem_we), .cmd_mem_addr(cmd_mem_addr),
    .cmd_mem_wdata(cmd_mem_wdata), .pay_mem_we(pay_mem_we),
    .pay_mem_addr(pay_mem_addr), .pay_mem_wdata(pay_mem_wdata), .busy(busy),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
    .sdo_valid(sdo_valid), .sdo_ready(sdo_ready), .sdo_byte(sdo_byte)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cmd(input bit rnw, input int len, input int addr);
    return {9'd0, 3'b000, 12'(len), 7'(addr), rnw};
  endfunction

  task automatic wr_cmd(input int a, input logic [31:0] d);
    @(negedge clk);
    cmd_mem_we = 1'b1; cmd_mem_addr = 4'(a); cmd_mem_wdata = d;
    @(negedge clk);
    cmd_mem_we = 1'b0;
    tb_cmd[a] = d;
  endtask

  task automatic wr_pay(input int a, input logic [31:0] d);
    @(negedge clk);
    pay_mem_we = 1'b1; pay_mem_addr = 4'(a); pay_mem_wdata = d;
    @(negedge clk);
    pay_mem_we = 1'b0;
    tb_pay[a] = d;
  endtask

  // expected streams, computed from the requirements
  task automatic build_expect(input int len);
    int pp = 0;
    n_exp_cmd = 0; n_exp_byte = 0;
    for (int i = 0; i < len; i++) begin
      int nb;
      exp_cmd[n_exp_cmd++] = tb_cmd[i];
      if (tb_cmd[i][0] == 1'b0) begin
        nb = int'(tb_cmd[i][19:8]);
        if (nb > 4) nb = 4;
        for (int b = 0; b < nb; b++) exp_byte[n_exp_byte++] = tb_pay[pp][8*b +: 8];
        pp = (pp + 1) % 16;
      end
    end
  endtask

  task automatic run_burst(input int len, input bit stall, input bit hold_trig,
                           input string req);
    int cyc = 0;
    build_expect(len);
    n_got_cmd = 0; n_got_byte = 0; both_hi = 0;
    @(negedge clk);
    burst_len = 4'(len); trigger = 1'b1;
    @(negedge clk);
    if (!hold_trig) trigger = 1'b0;
    check(busy === 1'b1 && cmd_valid === 1'b1, "R2 start", {30'd0, busy, cmd_valid}, 32'h3);
    check(cmd_word === tb_cmd[0], "R2 entry0", cmd_word, tb_cmd[0]);
    while (busy && cyc < 2000) begin
      cmd_ready = !stall || (cyc % 3 != 1);
      sdo_ready = !stall || (cyc % 4 != 2);
      if (cmd_valid && sdo_valid) both_hi++;
      if (cmd_valid && cmd_ready && n_got_cmd < 64) got_cmd[n_got_cmd++] = cmd_word;
      if (sdo_valid && sdo_ready && n_got_byte < 256) got_byte[n_got_byte++] = sdo_byte;
      cyc++;
      @(negedge clk);
    end
    trigger = 1'b0; cmd_ready = 1'b0; sdo_ready = 1'b0;
    check(cyc < 2000, {req, " watchdog"}, 32'(cyc), 32'd2000);
    check(both_hi == 0, "R10", 32'(both_hi), 32'd0);
    check(n_got_cmd == n_exp_cmd, {req, " R3 cmd count"}, 32'(n_got_cmd), 32'(n_exp_cmd));
    for (int i = 0; i < n_exp_cmd && i < n_got_cmd; i++)
      check(got_cmd[i] === exp_cmd[i], {req, " R3 cmd order"}, got_cmd[i], exp_cmd[i]);
    check(n_got_byte == n_exp_byte, {req, " R4 byte count"}, 32'(n_got_byte), 32'(n_exp_byte));
    for (int i = 0; i < n_exp_byte && i < n_got_byte; i++)
      check(got_byte[i] === exp_byte[i], {req, " R4 R5 byte"}, 32'(got_byte[i]), 32'(exp_byte[i]));
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && cmd_valid === 1'b0, {req, " R6 R7 stays idle"},
          {30'd0, busy, cmd_valid}, 32'd0);
  endtask

  task automatic t_reset;
    check(busy === 1'b0 && cmd_valid === 1'b0 && sdo_valid === 1'b0, "R1 reset",
          {29'd0, busy, cmd_valid, sdo_valid}, 32'd0);
  endtask

  task automatic t_basic;
    wr_cmd(0, mk_cmd(1'b0, 3, 7'h12));
    wr_cmd(1, mk_cmd(1'b0, 2, 7'h13));
    wr_cmd(2, mk_cmd(1'b1, 5, 7'h14));
    wr_pay(0, 32'h44332211);
    wr_pay(1, 32'h88776655);
    wr_pay(2, 32'hCCBBAA99);
    run_burst(3, 1'b0, 1'b0, "R3 R4 basic");
  endtask

  task automatic t_mixed_stall;
    wr_cmd(0, mk_cmd(1'b0, 0, 7'h20));
    wr_cmd(1, mk_cmd(1'b0, 7, 7'h21));
    wr_cmd(2, mk_cmd(1'b1, 2, 7'h22));
    wr_cmd(3, mk_cmd(1'b0, 1, 7'h23));
    wr_cmd(4, mk_cmd(1'b0, 4, 7'h24));
    wr_pay(3, 32'hF0E0D0C0);
    run_burst(5, 1'b1, 1'b0, "R4 R5 stall");
  endtask

  task automatic t_rewind;
    run_burst(2, 1'b0, 1'b0, "R6 first");
    run_burst(2, 1'b1, 1'b0, "R6 second");
  endtask

  task automatic t_trigger_busy;
    run_burst(5, 1'b0, 1'b1, "R7 held");
    run_burst(4, 1'b1, 1'b1, "R7 held stall");
  endtask

  task automatic t_mode_off;
    @(negedge clk);
    offload_en = 1'b0; burst_len = 4'd3; trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    repeat (3) begin
      check(busy === 1'b0 && cmd_valid === 1'b0, "R8 mode0", {30'd0, busy, cmd_valid}, 32'd0);
      @(negedge clk);
    end
    offload_en = 1'b1;
  endtask

  task automatic t_len_zero;
    @(negedge clk);
    burst_len = 4'd0; trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    repeat (3) begin
      check(busy === 1'b0 && cmd_valid === 1'b0 && sdo_valid === 1'b0, "R9 len0",
            {29'd0, busy, cmd_valid, sdo_valid}, 32'd0);
      @(negedge clk);
    end
  endtask

  task automatic t_rewrite;
    wr_cmd(0, mk_cmd(1'b0, 4, 7'h55));
    wr_pay(0, 32'hDEADBEEF);
    run_burst(1, 1'b0, 1'b0, "R11 rewrite");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      tb_cmd[i] = '0;
      tb_pay[i] = '0;
    end
    rst_n = 1'b0; offload_en = 1'b1; trigger = 1'b0; burst_len = '0;
    cmd_mem_we = 1'b0; pay_mem_we = 1'b0; cmd_mem_addr = '0; pay_mem_addr = '0;
    cmd_mem_wdata = '0; pay_mem_wdata = '0; cmd_ready = 1'b0; sdo_ready = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_mixed_stall();
    t_rewind();
    t_trigger_busy();
    t_mode_off();
    t_len_zero();
    t_rewrite();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule